// File: doc/BRIEF.md
# Immediate Command Mailbox Controller

This block lets software issue one 32-bit command to a peripheral on a serial link and pick up that peripheral's 32-bit reply through three memory-mapped registers, without a DMA ring. Software writes the command word, then writes 1 to a busy flag. The block presents the word on a valid/ready link port. Once the link accepts the word, the block waits for a reply. It stores the first reply it sees, clears busy and raises a result-valid flag. Software then reads the reply and clears the flag by writing 1 to it.

Several responders may answer in the same cycle. The block stores one of those answers, chosen by a fixed priority. Replies that arrive while no command is outstanding are dropped.

Top module: `imm_mailbox`

## Requirements
- R1: After reset the command register (0x60), the response register (0x64) and the status register (0x68) all read zero, and `cmd_valid` is low.
- R2: The command register at offset 0x60 is a 32-bit read/write register. A write to it while busy is 1 leaves its value unchanged.
- R3: In the status register, bit 0 is busy and bit 1 is result-valid. Bits 31:2 of a status read are zero.
- R4: If software writes 0x68 with bit 0 set while busy is 0, then after that clock edge busy reads 1, `cmd_valid` is high and `cmd_word` equals the command register.
- R5: `cmd_valid` stays high with `cmd_word` unchanged until a cycle in which `cmd_ready` is high, and it falls after that cycle. While busy is 1, writing 1 to busy starts no second command and writing 0 to busy has no effect.
- R6: A response is taken in a cycle where busy is 1, the command has already been accepted and any bit of `rsp_valid` is high. At that clock edge the response register takes the response word, result-valid goes to 1 and busy goes to 0.
- R7: Responses are discarded while busy is 0, and also while the command is still waiting for `cmd_ready`. In both cases the response register and the status register keep their values.
- R8: If several `rsp_valid` bits are high in the same cycle, the response from the lowest-indexed responder is stored. Responder i supplies its word on `rsp_data[32*i+31:32*i]`.
- R9: Writing 0x68 with bit 1 set clears result-valid. Writing 0x68 with bit 1 clear leaves result-valid unchanged.
- R10: If a response is taken in the same cycle that software writes 1 to result-valid, result-valid ends up 1.
- R11: The response register is read-only. Writes to 0x64 do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe; read data is zero when this is low |
| reg_rdata | output | 32 | Read data (combinational) |
| cmd_word | output | 32 | Command word sent to the link |
| cmd_valid | output | 1 | Command word is valid |
| cmd_ready | input | 1 | Link accepts the command word |
| rsp_valid | input | N_RESP | One response-valid bit per responder |
| rsp_data | input | 32*N_RESP | Response words, packed by responder index |

## Verification
The hardest case to reach is a response that arrives in the same cycle as a software write-1-to-clear of result-valid. Result-valid must already be 1 at that point, and a second command must be in flight. The bench gets there as follows. It completes a first command and leaves its flag uncleared. It launches a second command with a status write that has bit 1 clear, and lets the link accept it. It then drives a response and a status write of 0x2 in the same cycle. The bench also pulses responses while a command is still waiting for `cmd_ready`, which shows that no reply is taken before the command has left the block.

// File: rtl/imm_mailbox.sv
module imm_mailbox #(
  parameter int N_RESP = 3,
  parameter int AW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_we,
  input  logic                 reg_re,
  output logic [31:0]          reg_rdata,
  output logic [31:0]          cmd_word,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  input  logic [N_RESP-1:0]    rsp_valid,
  input  logic [32*N_RESP-1:0] rsp_data
);
  localparam logic [AW-1:0] A_CMD = AW'(8'h60);
  localparam logic [AW-1:0] A_RSP = AW'(8'h64);
  localparam logic [AW-1:0] A_STS = AW'(8'h68);

  logic [31:0] cmd_q, rsp_q;
  logic        busy_q, rv_q, pend_q;
  logic        hit;
  logic [31:0] pick;

  wire wr_cmd = reg_we && (reg_addr == A_CMD);
  wire wr_sts = reg_we && (reg_addr == A_STS);
  wire launch = wr_sts && reg_wdata[0] && !busy_q;
  wire take   = busy_q && !pend_q && hit;

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = N_RESP-1; i >= 0; i--)
      if (rsp_valid[i]) begin
        hit  = 1'b1;
        pick = rsp_data[32*i +: 32];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      rsp_q  <= '0;
      busy_q <= 1'b0;
      rv_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_cmd && !busy_q) cmd_q <= reg_wdata;
      if (take) rsp_q <= pick;
      if (take)        busy_q <= 1'b0;
      else if (launch) busy_q <= 1'b1;
      if (launch)                    pend_q <= 1'b1;
      else if (pend_q && cmd_ready)  pend_q <= 1'b0;
      if (take)                        rv_q <= 1'b1;
      else if (wr_sts && reg_wdata[1]) rv_q <= 1'b0;
    end
  end

  assign cmd_word  = cmd_q;
  assign cmd_valid = pend_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_re)
      case (reg_addr)
        A_CMD:   reg_rdata = cmd_q;
        A_RSP:   reg_rdata = rsp_q;
        A_STS:   reg_rdata = {30'd0, rv_q, busy_q};
        default: reg_rdata = '0;
      endcase
  end

  assert_cmd_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cmd_q));
  assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (cmd_valid && busy_q));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));
  assert_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy_q);
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !pend_q && (|rsp_valid)) |=> (!busy_q && rv_q));
  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q || pend_q) |=> $stable(rsp_q));
  assert_hw_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !pend_q && (|rsp_valid) && wr_sts && reg_wdata[1]) |=> rv_q);
endmodule

// File: tb/sim_imm_mailbox.sv
module sim_imm_mailbox;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, cmd_word;
  logic        reg_we = 0, reg_re = 0, cmd_valid, cmd_ready = 0;
  logic [2:0]  rsp_valid = 0;
  logic [95:0] rsp_data = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  imm_mailbox #(.N_RESP(3), .AW(8)) u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_re = 1; #1 d = reg_rdata; reg_re = 0;
  endtask

  task automatic rsp_pulse(logic [2:0] v, logic [95:0] d);
    @(negedge clk); rsp_valid = v; rsp_data = d;
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic accept();
    @(negedge clk); cmd_ready = 1;
    @(negedge clk); cmd_ready = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h60, d); chk("R1 cmd", d, 0);
    rd(8'h64, d); chk("R1 rsp", d, 0);
    rd(8'h68, d); chk("R1 sts", d, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
  endtask

  task automatic t_launch();
    logic [31:0] d;
    wr(8'h60, 32'hCAFE0001);
    rd(8'h60, d); chk("R2 rw", d, 32'hCAFE0001);
    wr(8'h68, 32'h1);
    chk("R4 valid", cmd_valid, 1);
    chk("R4 word", cmd_word, 32'hCAFE0001);
    rd(8'h68, d); chk("R4 busy", d, 32'h1);
    wr(8'h60, 32'h12345678);
    rd(8'h60, d); chk("R2 busy write", d, 32'hCAFE0001);
    wr(8'h68, 32'h0);
    rd(8'h68, d); chk("R5 write0", d, 32'h1);
    repeat (3) @(negedge clk);
    chk("R5 hold", cmd_valid, 1);
    chk("R5 stable", cmd_word, 32'hCAFE0001);
    rsp_pulse(3'b001, 96'h0BAD);
    rd(8'h64, d); chk("R7 pending drop", d, 0);
    accept();
    chk("R5 drop", cmd_valid, 0);
    wr(8'h68, 32'h1);
    chk("R5 no relaunch", cmd_valid, 0);
    rsp_pulse(3'b001, {64'd0, 32'hABCD0001});
    rd(8'h64, d); chk("R6 data", d, 32'hABCD0001);
    rd(8'h68, d); chk("R6 flags", d, 32'h2);
  endtask

  task automatic t_idle_and_w1c();
    logic [31:0] d;
    rsp_pulse(3'b010, {32'd0, 32'h7777, 32'd0});
    rd(8'h64, d); chk("R7 idle drop", d, 32'hABCD0001);
    rd(8'h68, d); chk("R7 idle sts", d, 32'h2);
    wr(8'h64, 32'hFFFFFFFF);
    rd(8'h64, d); chk("R11 ro", d, 32'hABCD0001);
    wr(8'h68, 32'hFFFFFFFC);
    rd(8'h68, d); chk("R9 write0", d, 32'h2);
    chk("R3 reserved", d & 32'hFFFFFFFC, 0);
    wr(8'h68, 32'h2);
    rd(8'h68, d); chk("R9 clear", d, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(8'h60, 32'h2); wr(8'h68, 32'h1); accept();
    rsp_pulse(3'b110, {32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000});
    rd(8'h64, d); chk("R8 pick1", d, 32'hBBBB0001);
    wr(8'h68, 32'h3); accept();
    rsp_pulse(3'b111, {32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000});
    rd(8'h64, d); chk("R8 pick0", d, 32'hAAAA0000);
  endtask

  task automatic t_hw_wins();
    logic [31:0] d;
    rd(8'h68, d); chk("R10 pre", d, 32'h2);
    wr(8'h68, 32'h1); accept();
    @(negedge clk);
    rsp_valid = 3'b100; rsp_data = {32'hD00D0003, 64'd0};
    reg_addr = 8'h68; reg_wdata = 32'h2; reg_we = 1;
    @(negedge clk); rsp_valid = 0; reg_we = 0;
    rd(8'h68, d); chk("R10 wins", d, 32'h2);
    rd(8'h64, d); chk("R10 data", d, 32'hD00D0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_launch();
    t_idle_and_w1c();
    t_priority();
    t_hw_wins();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule